// File: doc/BRIEF.md
# Data-space access router

This block sits between an 8051-style core and its on-chip data storage. Each cycle the core may raise one of three request kinds: a direct access, an indirect access through a register pointer, or an external-data move. The block picks the storage that the address and the kind select. The choices are general RAM, which is split into a lower and an upper half, the special function register (SFR) area, and a 256-byte auxiliary RAM. Any other request goes to the external bus interface.

The upper half of the 8-bit address space leads to two different places. A direct access there reaches the SFR area, and an indirect access reaches the upper RAM. An external-data move to addresses 0 to 255 is served from the auxiliary RAM. While the core fetches code from internal memory, that move must not disturb the external bus. The block models all storage as plain internal arrays. Reads answer one clock after the request, and writes commit on the edge that samples the request.

Top module: `dmem_router`

## Requirements
- R1: A direct or indirect access with address bits [7:0] below 128 reads or writes one shared lower RAM, so data written by one kind can be read back by the other. For these two kinds, address bits [15:8] are ignored.
- R2: An indirect access with address bits [7:0] from 128 to 255 reaches the upper RAM, which is storage separate from the SFR area.
- R3: A direct access with address bits [7:0] from 128 to 255 reaches the 128-byte SFR area, indexed by address bits [6:0]. It never reaches the upper RAM.
- R4: An external-data move with a 16-bit address from 0 to 255 reaches the auxiliary RAM. This storage is separate from general RAM at the same address.
- R5: An auxiliary RAM access made while `int_code_i` is 1 keeps `ext_req_o` and `ext_we_o` at 0. When `int_code_i` is 0, the same access raises `ext_req_o` and still uses the auxiliary RAM for its data.
- R6: An external-data move with an address of 256 or more raises `ext_req_o` in the request cycle and puts the address on `ext_addr_o`, `we_i` on `ext_we_o` and the write data on `ext_wdata_o`. It does not touch the auxiliary RAM. A read of this kind returns the `ext_rdata_i` value sampled at the request edge.
- R7: `rvalid_o` is 1 in exactly the cycle after each valid read request, with `rdata_o` holding the data. It is 0 after writes and after idle cycles.
- R8: A request with more than one of `dir_i`, `ind_i`, `xmov_i` set raises `err_o` in the next cycle. Such a request writes nothing, gives no `rvalid_o` and keeps `ext_req_o` at 0.
- R9: While `rst_ni` is low, `rvalid_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dir_i | input | 1 | Direct-access request |
| ind_i | input | 1 | Indirect-access request |
| xmov_i | input | 1 | External-data move request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Address; direct and indirect requests use bits [7:0] |
| wdata_i | input | 8 | Write data |
| int_code_i | input | 1 | Core is fetching code from internal memory |
| ext_rdata_i | input | 8 | Read data from the external bus |
| rdata_o | output | 8 | Read data, valid when rvalid_o is 1 |
| rvalid_o | output | 1 | Read data valid, one cycle after the request |
| err_o | output | 1 | Conflicting request flags were seen the cycle before |
| ext_req_o | output | 1 | Bus-drive request to the external bus interface |
| ext_addr_o | output | 16 | External bus address (0 when not requesting) |
| ext_we_o | output | 1 | External bus write strobe request |
| ext_wdata_o | output | 8 | External bus write data (0 when not requesting) |

## Verification
The same byte addresses are written with different values through each request kind, at 0x10, 0x7F, 0x80 and 0xFF. The bench then reads every value back, which separates the lower RAM, upper RAM, SFR area and auxiliary RAM from one another. Moves above 255 use addresses whose low byte matches auxiliary locations that already hold data, so an aliasing fault shows up in a later auxiliary read. The auxiliary accesses are repeated with `int_code_i` at both values to show when the bus request is held off. Conflicting flag pairs target locations that hold known data, and back-to-back reads from different storages check the one-cycle return path.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_LRAM,
    TGT_URAM,
    TGT_SFR,
    TGT_AUX,
    TGT_EXT
  } tgt_e;
endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
  import dmem_pkg::*;
#(
  parameter int RAM_DEPTH = 256,
  parameter int SFR_DEPTH = 128,
  parameter int AUX_DEPTH = 256,
  parameter int XAW       = 16
) (
  input  logic           dir_i,
  input  logic           ind_i,
  input  logic           xmov_i,
  input  logic [XAW-1:0] addr_i,
  input  logic           int_code_i,
  output tgt_e           tgt_o,
  output logic           err_o,
  output logic           ext_drive_o
);
  localparam int RAM_AW   = $clog2(RAM_DEPTH);
  localparam int SFR_BASE = RAM_DEPTH - SFR_DEPTH;

  logic [1:0] n_req;
  logic       low_half;
  logic       aux_hit;

  assign n_req    = 2'(dir_i) + 2'(ind_i) + 2'(xmov_i);
  assign low_half = 32'(addr_i[RAM_AW-1:0]) < SFR_BASE;
  assign aux_hit  = 32'(addr_i) < AUX_DEPTH;

  always_comb begin
    tgt_o       = TGT_NONE;
    err_o       = 1'b0;
    ext_drive_o = 1'b0;
    if (n_req > 2'd1) begin
      err_o = 1'b1;
    end else if (dir_i) begin
      tgt_o = low_half ? TGT_LRAM : TGT_SFR;
    end else if (ind_i) begin
      tgt_o = low_half ? TGT_LRAM : TGT_URAM;
    end else if (xmov_i) begin
      if (aux_hit) begin
        tgt_o       = TGT_AUX;
        ext_drive_o = !int_code_i; // bus mirrors the cycle only when code runs off-chip
      end else begin
        tgt_o       = TGT_EXT;
        ext_drive_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmem_ram.sv
module dmem_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/dmem_router.sv
module dmem_router
  import dmem_pkg::*;
#(
  parameter int RAM_DEPTH = 256,
  parameter int SFR_DEPTH = 128,
  parameter int AUX_DEPTH = 256,
  parameter int DW        = 8,
  parameter int XAW       = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           dir_i,
  input  logic           ind_i,
  input  logic           xmov_i,
  input  logic           we_i,
  input  logic [XAW-1:0] addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           int_code_i,
  input  logic [DW-1:0]  ext_rdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic           rvalid_o,
  output logic           err_o,
  output logic           ext_req_o,
  output logic [XAW-1:0] ext_addr_o,
  output logic           ext_we_o,
  output logic [DW-1:0]  ext_wdata_o
);
  localparam int RAM_AW = $clog2(RAM_DEPTH);
  localparam int SFR_AW = $clog2(SFR_DEPTH);
  localparam int AUX_AW = $clog2(AUX_DEPTH);

  tgt_e          tgt, tgt_q;
  logic          err, ext_drive;
  logic          rd_q, err_q;
  logic [DW-1:0] ram_rd, sfr_rd, aux_rd, ext_q;

  dmem_decode #(
    .RAM_DEPTH(RAM_DEPTH), .SFR_DEPTH(SFR_DEPTH),
    .AUX_DEPTH(AUX_DEPTH), .XAW(XAW)
  ) u_dec (
    .dir_i      (dir_i),
    .ind_i      (ind_i),
    .xmov_i     (xmov_i),
    .addr_i     (addr_i),
    .int_code_i (int_code_i),
    .tgt_o      (tgt),
    .err_o      (err),
    .ext_drive_o(ext_drive)
  );

  // lower and upper halves share one array; decode only keeps SFR traffic out
  dmem_ram #(.DEPTH(RAM_DEPTH), .DW(DW)) u_ram (
    .clk_i  (clk_i),
    .we_i   (we_i && (tgt == TGT_LRAM || tgt == TGT_URAM)),
    .addr_i (addr_i[RAM_AW-1:0]),
    .wdata_i(wdata_i),
    .rdata_o(ram_rd)
  );

  dmem_ram #(.DEPTH(SFR_DEPTH), .DW(DW)) u_sfr (
    .clk_i  (clk_i),
    .we_i   (we_i && tgt == TGT_SFR),
    .addr_i (addr_i[SFR_AW-1:0]),
    .wdata_i(wdata_i),
    .rdata_o(sfr_rd)
  );

  dmem_ram #(.DEPTH(AUX_DEPTH), .DW(DW)) u_aux (
    .clk_i  (clk_i),
    .we_i   (we_i && tgt == TGT_AUX),
    .addr_i (addr_i[AUX_AW-1:0]),
    .wdata_i(wdata_i),
    .rdata_o(aux_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= TGT_NONE;
      rd_q  <= 1'b0;
      err_q <= 1'b0;
      ext_q <= '0;
    end else begin
      tgt_q <= tgt;
      rd_q  <= (tgt != TGT_NONE) && !we_i;
      err_q <= err;
      if (tgt == TGT_EXT && !we_i) ext_q <= ext_rdata_i;
    end
  end

  always_comb begin
    unique case (tgt_q)
      TGT_LRAM, TGT_URAM: rdata_o = ram_rd;
      TGT_SFR:            rdata_o = sfr_rd;
      TGT_AUX:            rdata_o = aux_rd;
      TGT_EXT:            rdata_o = ext_q;
      default:            rdata_o = '0;
    endcase
  end

  assign rvalid_o    = rd_q;
  assign err_o       = err_q;
  assign ext_req_o   = ext_drive;
  assign ext_addr_o  = ext_drive ? addr_i : '0;
  assign ext_we_o    = ext_drive && we_i;
  assign ext_wdata_o = ext_drive ? wdata_i : '0;
endmodule

// File: rtl/dmem_router_chk.sv
module dmem_router_chk #(
  parameter int AUX_DEPTH = 256,
  parameter int DW        = 8,
  parameter int XAW       = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           dir_i,
  input logic           ind_i,
  input logic           xmov_i,
  input logic           we_i,
  input logic [XAW-1:0] addr_i,
  input logic           int_code_i,
  input logic [DW-1:0]  ext_rdata_i,
  input logic [DW-1:0]  rdata_o,
  input logic           rvalid_o,
  input logic           err_o,
  input logic           ext_req_o,
  input logic [XAW-1:0] ext_addr_o,
  input logic           ext_we_o
);
  logic multi, single, xonly, aux_a, far_a;
  assign multi  = $countones({dir_i, ind_i, xmov_i}) > 1;
  assign single = $countones({dir_i, ind_i, xmov_i}) == 1;
  assign xonly  = xmov_i && !dir_i && !ind_i;
  assign aux_a  = xonly && (32'(addr_i) < AUX_DEPTH);
  assign far_a  = xonly && !(32'(addr_i) < AUX_DEPTH);

  p_multi_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi |=> (err_o && !rvalid_o));
  p_multi_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi |-> !ext_req_o);
  p_aux_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_a && int_code_i) |-> (!ext_req_o && !ext_we_o));
  p_aux_mirror_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_a && !int_code_i) |-> ext_req_o);
  p_far_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    far_a |-> (ext_req_o && ext_addr_o == addr_i && ext_we_o == we_i));
  p_far_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (far_a && !we_i) |=> (rdata_o == $past(ext_rdata_i)));
  p_read_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single && !we_i) |=> rvalid_o);
  p_no_spur_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(single && !we_i) |=> !rvalid_o);
  always_comb if (!rst_ni) p_reset_r9: assert (!rvalid_o && !err_o);
endmodule

bind dmem_router dmem_router_chk #(.AUX_DEPTH(AUX_DEPTH), .DW(DW), .XAW(XAW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dir_i(dir_i), .ind_i(ind_i), .xmov_i(xmov_i),
  .we_i(we_i), .addr_i(addr_i), .int_code_i(int_code_i), .ext_rdata_i(ext_rdata_i),
  .rdata_o(rdata_o), .rvalid_o(rvalid_o), .err_o(err_o), .ext_req_o(ext_req_o),
  .ext_addr_o(ext_addr_o), .ext_we_o(ext_we_o)
);

// File: tb/dmem_router_tb_top.sv
module dmem_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir = 0, ind = 0, xmov = 0, we = 0, int_code = 1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0, ext_rdata = '0;
  logic [7:0]  rdata;
  logic        rvalid, err, ext_req, ext_we;
  logic [15:0] ext_addr;
  logic [7:0]  ext_wdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit       is_err;
    logic [7:0] d;
    string    tag;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  dmem_router dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dir_i(dir), .ind_i(ind), .xmov_i(xmov),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .int_code_i(int_code),
    .ext_rdata_i(ext_rdata), .rdata_o(rdata), .rvalid_o(rvalid), .err_o(err),
    .ext_req_o(ext_req), .ext_addr_o(ext_addr), .ext_we_o(ext_we),
    .ext_wdata_o(ext_wdata)
  );

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one request per cycle; exp_ext is the expected bus-drive request
  task automatic req(bit d, bit i, bit x, bit w, logic [15:0] a, logic [7:0] wd,
                     logic [7:0] exp, string tag, bit exp_ext = 0, logic [7:0] xr = 8'h00);
    int n;
    @(negedge clk);
    dir = d; ind = i; xmov = x; we = w; addr = a; wdata = wd; ext_rdata = xr;
    #1;
    check(ext_req == exp_ext, {tag, " ext_req"}, 16'(ext_req), 16'(exp_ext));
    if (exp_ext) begin
      check(ext_addr == a && ext_we == w, {tag, " ext addr/we"},
            {ext_addr[14:0], ext_we}, {a[14:0], w});
      if (w) check(ext_wdata == wd, {tag, " ext wdata"}, 16'(ext_wdata), 16'(wd));
    end else begin
      check(!ext_we, {tag, " ext_we quiet"}, 16'(ext_we), 16'h0);
    end
    @(posedge clk);
    #1;
    n = int'(d) + int'(i) + int'(x);
    if (n > 1) q.push_back('{1'b1, 8'h00, tag});
    else if (n == 1 && !w) q.push_back('{1'b0, exp, tag});
    dir = 0; ind = 0; xmov = 0; we = 0;
  endtask

  // monitor: pops one expectation per result cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        if (it.is_err) begin
          check(err && !rvalid, {it.tag, " err/no rvalid"}, {err, rvalid}, 16'h2);
        end else begin
          check(rvalid && !err, {it.tag, " rvalid"}, {err, rvalid}, 16'h1);
          check(rdata == it.d, {it.tag, " rdata"}, 16'(rdata), 16'(it.d));
        end
      end else if (rvalid || err) begin
        check(1'b0, "R7 spurious rvalid/err", {err, rvalid}, 16'h0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 16'h0, 16'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!rvalid && !err && !ext_req, "R9 reset outputs", {ext_req, err, rvalid}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 lower RAM shared by direct and indirect, upper addr bits ignored
    req(1,0,0,1, 16'h0010, 8'hA5, 8'h00, "R1 dir wr 10");
    req(0,1,0,0, 16'h0010, 8'h00, 8'hA5, "R1 ind rd 10");
    req(0,1,0,1, 16'h007F, 8'h3C, 8'h00, "R1 ind wr 7F");
    req(1,0,0,0, 16'hAB7F, 8'h00, 8'h3C, "R1 dir rd 7F hi bits");

    // R2/R3 same upper address, different storage
    req(0,1,0,1, 16'h0080, 8'h11, 8'h00, "R2 ind wr 80");
    req(1,0,0,1, 16'h0080, 8'h22, 8'h00, "R3 dir wr 80");
    req(0,1,0,1, 16'h00FF, 8'h33, 8'h00, "R2 ind wr FF");
    req(1,0,0,1, 16'h00FF, 8'h44, 8'h00, "R3 dir wr FF");
    req(0,1,0,0, 16'h0080, 8'h00, 8'h11, "R2 ind rd 80");
    req(1,0,0,0, 16'h0080, 8'h00, 8'h22, "R3 dir rd 80");
    req(0,1,0,0, 16'h00FF, 8'h00, 8'h33, "R2 ind rd FF");
    req(1,0,0,0, 16'h00FF, 8'h00, 8'h44, "R3 dir rd FF");

    // R4/R5 aux RAM, internal code: bus stays quiet
    int_code = 1;
    req(0,0,1,1, 16'h0010, 8'h77, 8'h00, "R5 aux wr 10 quiet");
    req(0,0,1,1, 16'h0000, 8'h01, 8'h00, "R4 aux wr 00");
    req(0,0,1,1, 16'h00FF, 8'h5E, 8'h00, "R4 aux wr FF");
    req(0,1,0,0, 16'h0010, 8'h00, 8'hA5, "R4 ram 10 untouched");
    req(0,0,1,0, 16'h0010, 8'h00, 8'h77, "R4 aux rd 10");
    req(0,0,1,0, 16'h00FF, 8'h00, 8'h5E, "R4 aux rd FF");

    // R5 external code: bus mirrors aux access, data still in aux
    int_code = 0;
    req(0,0,1,1, 16'h0020, 8'h6B, 8'h00, "R5 aux wr 20 mirrored", 1);
    req(0,0,1,0, 16'h0020, 8'h00, 8'h6B, "R5 aux rd 20 mirrored", 1, 8'hC3);
    int_code = 1;

    // R6 far moves go to the bus and leave aux alone
    req(0,0,1,1, 16'h0100, 8'hEE, 8'h00, "R6 far wr 0100", 1);
    req(0,0,1,1, 16'h12FF, 8'hDD, 8'h00, "R6 far wr 12FF", 1);
    req(0,0,1,0, 16'h0100, 8'h00, 8'h5A, "R6 far rd 0100", 1, 8'h5A);
    req(0,0,1,0, 16'hFFFF, 8'h00, 8'h96, "R6 far rd FFFF", 1, 8'h96);
    req(0,0,1,0, 16'h0000, 8'h00, 8'h01, "R6 aux 00 unaliased");
    req(0,0,1,0, 16'h00FF, 8'h00, 8'h5E, "R6 aux FF unaliased");

    // R8 conflicting flags: error, no write, no bus
    req(1,1,0,1, 16'h0010, 8'h99, 8'h00, "R8 dir+ind wr 10");
    req(1,0,1,1, 16'h0080, 8'h98, 8'h00, "R8 dir+xmov wr 80");
    req(0,1,1,0, 16'h0100, 8'h00, 8'h00, "R8 ind+xmov far rd", 0, 8'h77);
    req(1,1,1,1, 16'h0010, 8'h97, 8'h00, "R8 all flags");
    req(1,0,0,0, 16'h0010, 8'h00, 8'hA5, "R8 ram 10 kept");
    req(1,0,0,0, 16'h0080, 8'h00, 8'h22, "R8 sfr 80 kept");
    req(0,0,1,0, 16'h0010, 8'h00, 8'h77, "R8 aux 10 kept");

    // R7 back-to-back reads across storages, then idle
    req(0,1,0,0, 16'h007F, 8'h00, 8'h3C, "R7 b2b ram");
    req(1,0,0,0, 16'h00FF, 8'h00, 8'h44, "R7 b2b sfr");
    req(0,0,1,0, 16'h0000, 8'h00, 8'h01, "R7 b2b aux");
    req(0,0,1,0, 16'h4000, 8'h00, 8'h3E, "R7 b2b ext", 1, 8'h3E);
    req(0,1,0,0, 16'h0080, 8'h00, 8'h11, "R7 b2b uram");

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R7 all results seen", 16'(q.size()), 16'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule